// File: doc/BRIEF.md
# Indexed Bit Operation Sequencer

This block executes the four-byte indexed bit-manipulation instruction of an 8-bit processor. Bytes arrive one at a time on a valid-qualified byte input. The first byte is an index prefix, either 0xDD for the first index register or 0xFD for the second. The second byte is the 0xCB escape. The third is a signed 8-bit offset, and the fourth is the operation byte. Once the fourth byte is in, the sequencer forms the effective address and reads one byte from a synchronous memory. It then transforms that byte with a shift, rotate, bit-set, bit-clear or bit-test operation. Last, it issues the memory write and, when asked, a copy of the same byte into one general register, both in the same cycle.

The operation byte is split into three fields. Bits 7:6 give the operation class. Bits 5:3 give the bit number or the shift kind. Bits 2:0 name a general register that receives a copy of the new value. The code 110 in bits 2:0 means that no register is copied. A bit test only reports flags and never writes anything. The surrounding processor supplies both index values, the incoming carry, the memory and the register file.

Top module: `idxbit_seq`

## Requirements
- R1: A sequence starts only on an accepted byte of 0xDD or 0xFD while idle. Any other byte while idle is ignored. If the byte after the prefix is not 0xCB, the sequence is abandoned with no memory access. The next accepted bytes are then the offset and the operation byte.
- R2: The effective address is the selected index plus the sign-extended offset, modulo 65536. Prefix 0xDD selects `ix_val` and 0xFD selects `iy_val`.
- R3: Each instruction makes exactly one memory read, on the second cycle after the operation byte is accepted. Read data is taken one cycle after the read strobe. Any write comes exactly two cycles after the read, to the same address. Read and write are never asserted together.
- R4: Operation byte bits 7:6 select the class: 00 shift/rotate, 01 bit test, 10 clear bit, 11 set bit. For clear and set, bits 5:3 give the bit number.
- R5: For shift/rotate, bits 5:3 select the kind. 0 rotates left with bit 7 into bit 0. 1 rotates right with bit 0 into bit 7. 2 rotates left through carry. 3 rotates right through carry. 4 shifts left and fills 0. 5 shifts right and keeps bit 7. 6 shifts left and fills 1. 7 shifts right and fills 0.
- R6: Shift/rotate raises `flag_we` in the final cycle. `flag_c` is the bit shifted out, and `flag_z` is set when the result is zero. Clear and set do not raise `flag_we`.
- R7: For every class except bit test, when bits 2:0 are not 110, `reg_we` pulses in the same cycle as `mem_wr`. `reg_sel` equals bits 2:0 (000 B, 001 C, 010 D, 011 E, 100 H, 101 L, 111 A), and `reg_wdata` equals `mem_wdata`.
- R8: When bits 2:0 are 110, only memory is written and `reg_we` stays low.
- R9: The register copy holds the computed value even when the memory ignores the write, for example read-only space. The result is never read back from memory.
- R10: A bit test (class 01) writes neither memory nor a register for any value of bits 2:0. It raises `flag_we` with `flag_z` set when the tested bit is 0, and `flag_c` equal to `carry_in`.
- R11: `done` is a one-cycle pulse in the final cycle of each instruction. `busy` is high from the cycle after the prefix is accepted until the sequence returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Instruction byte present on `byte_in` |
| byte_in | input | 8 | Instruction byte stream |
| ix_val | input | 16 | First index register value |
| iy_val | input | 16 | Second index register value |
| carry_in | input | 1 | Current carry flag |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe; data is expected on the next cycle |
| mem_rdata | input | 8 | Memory read data |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| reg_we | output | 1 | Register-file write enable |
| reg_sel | output | 3 | Register-file write index |
| reg_wdata | output | 8 | Register-file write data |
| flag_we | output | 1 | Flag update enable |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final cycle of an instruction |

## Verification
A wrong sequencer state appears at the ports within one or two cycles. It shows as a read strobe that comes early or is missing, a write that does not trail the read by exactly two cycles, or a `done` pulse that is repeated or absent. A wrong decode of the operation byte shows in the final cycle. It appears as a register write for code 110 or for a bit test, a register byte that differs from the memory byte, or flags raised for set and clear. A wrong address sum or index selection shows on `mem_addr` at the read strobe. Offsets that wrap past 0xFFFF or below zero, and writes into read-only space, target the paths most likely to hide such faults.

// File: rtl/idxbit_pkg.sv
package idxbit_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    localparam logic [7:0] PFX_IX  = 8'hDD;
    localparam logic [7:0] PFX_IY  = 8'hFD;
    localparam logic [7:0] ESC_BIT = 8'hCB;
    localparam logic [2:0] NO_COPY = 3'b110;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_TEST  = 2'b01,
        CLS_CLR   = 2'b10,
        CLS_SET   = 2'b11
    } op_class_e;

    typedef enum logic [2:0] {
        SH_ROL  = 3'd0,
        SH_ROR  = 3'd1,
        SH_RLC  = 3'd2,
        SH_RRC  = 3'd3,
        SH_SL0  = 3'd4,
        SH_SRS  = 3'd5,
        SH_SL1  = 3'd6,
        SH_SR0  = 3'd7
    } shift_kind_e;

    // Operation byte layout: class, sub-field, copy target.
    typedef struct packed {
        op_class_e  cls;
        logic [2:0] sub;
        logic [2:0] dst;
    } op_dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              zero;
        logic              carry;
    } alu_res_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ESC,
        ST_DISP,
        ST_OPC,
        ST_AGEN,
        ST_READ,
        ST_CALC,
        ST_WB
    } seq_state_e;

    function automatic alu_res_t alu_eval(input op_dec_t op,
                                          input logic [DATA_W-1:0] b,
                                          input logic cin);
        alu_res_t r;
        r.value = b;
        r.carry = cin;
        unique case (op.cls)
            CLS_SHIFT: begin
                unique case (shift_kind_e'(op.sub))
                    SH_ROL: begin r.value = {b[DATA_W-2:0], b[DATA_W-1]}; r.carry = b[DATA_W-1]; end
                    SH_ROR: begin r.value = {b[0], b[DATA_W-1:1]};        r.carry = b[0];        end
                    SH_RLC: begin r.value = {b[DATA_W-2:0], cin};         r.carry = b[DATA_W-1]; end
                    SH_RRC: begin r.value = {cin, b[DATA_W-1:1]};         r.carry = b[0];        end
                    SH_SL0: begin r.value = {b[DATA_W-2:0], 1'b0};        r.carry = b[DATA_W-1]; end
                    SH_SRS: begin r.value = {b[DATA_W-1], b[DATA_W-1:1]}; r.carry = b[0];        end
                    SH_SL1: begin r.value = {b[DATA_W-2:0], 1'b1};        r.carry = b[DATA_W-1]; end
                    SH_SR0: begin r.value = {1'b0, b[DATA_W-1:1]};        r.carry = b[0];        end
                    default: ;
                endcase
                r.zero = (r.value == '0);
            end
            CLS_TEST: r.zero = ~b[op.sub];
            CLS_CLR: begin
                r.value[op.sub] = 1'b0;
                r.zero = (r.value == '0);
            end
            default: begin
                r.value[op.sub] = 1'b1;
                r.zero = (r.value == '0);
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/idxbit_ctrl.sv
module idxbit_ctrl
    import idxbit_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    output seq_state_e        state,
    output logic              use_iy,
    output logic [BYTE_W-1:0] disp,
    output op_dec_t           op
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            use_iy <= 1'b0;
            disp   <= '0;
            op     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (byte_valid && (byte_in == PFX_IX || byte_in == PFX_IY)) begin
                    use_iy <= (byte_in == PFX_IY);
                    state  <= ST_ESC;
                end
                ST_ESC: if (byte_valid) begin
                    state <= (byte_in == ESC_BIT) ? ST_DISP : ST_IDLE;
                end
                ST_DISP: if (byte_valid) begin
                    disp  <= byte_in;
                    state <= ST_OPC;
                end
                ST_OPC: if (byte_valid) begin
                    op    <= op_dec_t'(byte_in);
                    state <= ST_AGEN;
                end
                ST_AGEN: state <= ST_READ;
                ST_READ: state <= ST_CALC;
                ST_CALC: state <= ST_WB;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/idxbit_agen.sv
module idxbit_agen #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ea_ld,
    input  logic              use_iy,
    input  logic [ADDR_W-1:0] ix_val,
    input  logic [ADDR_W-1:0] iy_val,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offs;

    always_comb begin
        base = use_iy ? iy_val : ix_val;
        offs = {{EXT_W{disp[DISP_W-1]}}, disp};
    end

    always_ff @(posedge clk) begin
        if (rst)        ea <= '0;
        else if (ea_ld) ea <= base + offs;
    end

endmodule

// File: rtl/idxbit_alu.sv
module idxbit_alu
    import idxbit_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          res_ld,
    input  op_dec_t       op,
    input  logic [DW-1:0] operand,
    input  logic          cin,
    output alu_res_t      res
);

    alu_res_t nxt;

    always_comb nxt = alu_eval(op, operand, cin);

    always_ff @(posedge clk) begin
        if (rst)         res <= '0;
        else if (res_ld) res <= nxt;
    end

endmodule

// File: rtl/idxbit_seq.sv
module idxbit_seq
    import idxbit_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_valid,
    input  logic [7:0]    byte_in,
    input  logic [AW-1:0] ix_val,
    input  logic [AW-1:0] iy_val,
    input  logic          carry_in,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          reg_we,
    output logic [2:0]    reg_sel,
    output logic [DW-1:0] reg_wdata,
    output logic          flag_we,
    output logic          flag_z,
    output logic          flag_c,
    output logic          busy,
    output logic          done
);

    seq_state_e state;
    logic       use_iy;
    logic [7:0] disp;
    op_dec_t    op;
    alu_res_t   res;
    logic       is_test;
    logic       wb;

    idxbit_ctrl #(.BYTE_W(8)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .byte_valid(byte_valid),
        .byte_in   (byte_in),
        .state     (state),
        .use_iy    (use_iy),
        .disp      (disp),
        .op        (op)
    );

    idxbit_agen #(.ADDR_W(AW), .DISP_W(8)) u_agen (
        .clk   (clk),
        .rst   (rst),
        .ea_ld (state == ST_AGEN),
        .use_iy(use_iy),
        .ix_val(ix_val),
        .iy_val(iy_val),
        .disp  (disp),
        .ea    (mem_addr)
    );

    idxbit_alu #(.DW(DW)) u_alu (
        .clk    (clk),
        .rst    (rst),
        .res_ld (state == ST_CALC),
        .op     (op),
        .operand(mem_rdata),
        .cin    (carry_in),
        .res    (res)
    );

    always_comb begin
        wb        = (state == ST_WB);
        is_test   = (op.cls == CLS_TEST);
        mem_rd    = (state == ST_READ);
        mem_wr    = wb && !is_test;
        mem_wdata = res.value;
        reg_we    = wb && !is_test && (op.dst != NO_COPY);
        reg_sel   = op.dst;
        reg_wdata = res.value;
        flag_we   = wb && (op.cls == CLS_SHIFT || is_test);
        flag_z    = res.zero;
        flag_c    = res.carry;
        busy      = (state != ST_IDLE);
        done      = wb;
    end

endmodule

// File: rtl/idxbit_seq_chk.sv
module idxbit_seq_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] mem_wdata,
    input logic          reg_we,
    input logic [2:0]    reg_sel,
    input logic [DW-1:0] reg_wdata,
    input logic          flag_we,
    input logic          busy,
    input logic          done
);

    a_r3_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r3_write_after_read: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd, 2));

    a_r3_same_addr: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_addr == $past(mem_addr, 2));

    a_r7_reg_mirrors_mem: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (mem_wr && reg_wdata == mem_wdata));

    a_r8_no_copy_code: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> reg_sel != 3'b110);

    a_r10_test_writes_nothing: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !mem_wr) |-> !reg_we);

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_when_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

endmodule

bind idxbit_seq idxbit_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_wdata(mem_wdata),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .flag_we  (flag_we),
    .busy     (busy),
    .done     (done)
);

// File: tb/idxbit_seq_bench.sv
module idxbit_seq_bench;

    typedef struct packed {
        logic [7:0]  pfx;
        logic [15:0] idx;
        logic [7:0]  d;
        logic [7:0]  op;
        logic        cin;
        logic [7:0]  init;
        logic [15:0] ea;
        logic [7:0]  res;
        logic        regwe;
        logic        rom;
        logic        flgwe;
        logic        z;
        logic        c;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'hDD, 16'h1000, 8'h05, 8'h06, 1'b0, 8'h81, 16'h1005, 8'h03, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'hDD, 16'h1000, 8'h05, 8'h00, 1'b0, 8'h81, 16'h1005, 8'h03, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'hFD, 16'h2010, 8'hFE, 8'h37, 1'b0, 8'h40, 16'h200E, 8'h81, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hDD, 16'h3000, 8'h10, 8'hC7, 1'b0, 8'h00, 16'h3010, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'hFD, 16'h0400, 8'h03, 8'hBD, 1'b0, 8'hFF, 16'h0403, 8'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'hDD, 16'h1000, 8'h01, 8'h7B, 1'b0, 8'h7F, 16'h1001, 8'h7F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{8'hDD, 16'h1000, 8'h01, 8'h46, 1'b1, 8'h01, 16'h1001, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'hDD, 16'h0050, 8'h00, 8'h1A, 1'b1, 8'h01, 16'h0050, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'hDD, 16'h8000, 8'h02, 8'hE1, 1'b0, 8'h00, 16'h8002, 8'h10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'hDD, 16'hFFFF, 8'h02, 8'h3C, 1'b0, 8'h80, 16'h0001, 8'h40, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hFD, 16'h0000, 8'h80, 8'h2F, 1'b0, 8'h80, 16'hFF80, 8'hC0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{8'hDD, 16'h0100, 8'h7F, 8'h22, 1'b0, 8'h80, 16'h017F, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [15:0] ix_val = 16'h0000;
    logic [15:0] iy_val = 16'h0000;
    logic        carry_in = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [7:0]  reg_wdata;
    logic        flag_we;
    logic        flag_z;
    logic        flag_c;
    logic        busy;
    logic        done;

    always #5 clk = ~clk;

    idxbit_seq u_idxbit_seq (.*);

    // Memory model: read data one cycle after strobe; addr bit 15 set is read-only.
    logic [7:0]  mem [256];
    logic        pre_en = 1'b0;
    logic [7:0]  pre_addr = 8'h00;
    logic [7:0]  pre_data = 8'h00;
    int          cyc = 0;
    int          rd_cnt = 0, wr_cnt = 0, rg_cnt = 0, fl_cnt = 0;
    int          rd_cyc = 0, wr_cyc = 0;
    logic [15:0] rd_addr = '0, wr_addr = '0;
    logic [2:0]  rg_sel = '0;
    logic [7:0]  rg_data = '0;
    logic        fl_z = 1'b0, fl_c = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pre_en) mem[pre_addr] <= pre_data;
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[7:0]];
            rd_cnt    <= rd_cnt + 1;
            rd_cyc    <= cyc;
            rd_addr   <= mem_addr;
        end
        if (mem_wr) begin
            if (!mem_addr[15]) mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt  <= wr_cnt + 1;
            wr_cyc  <= cyc;
            wr_addr <= mem_addr;
        end
        if (reg_we) begin
            rg_cnt  <= rg_cnt + 1;
            rg_sel  <= reg_sel;
            rg_data <= reg_wdata;
        end
        if (flag_we) begin
            fl_cnt <= fl_cnt + 1;
            fl_z   <= flag_z;
            fl_c   <= flag_c;
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic preload(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        pre_en = 1'b1; pre_addr = a; pre_data = v;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit ok;
        int rd0, wr0, rg0, fl0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!busy && !done && !mem_rd && !mem_wr && !reg_we && !flag_we, "R11 reset idle",
              {busy, done, mem_rd, mem_wr, reg_we, flag_we}, 0);

        foreach (VECS[i]) begin
            vec_t v;
            v = VECS[i];
            preload(v.ea[7:0], v.init);
            ix_val   = (v.pfx == 8'hDD) ? v.idx : 16'hA5A5;
            iy_val   = (v.pfx == 8'hFD) ? v.idx : 16'hA5A5;
            carry_in = v.cin;
            rd0 = rd_cnt; wr0 = wr_cnt; rg0 = rg_cnt; fl0 = fl_cnt;
            send(v.pfx);
            check(busy, "R11 busy after prefix", busy, 1);
            send(8'hCB);
            send(v.d);
            send(v.op);
            wait_done(ok);
            check(ok, "R11 done pulse", ok, 1);
            check(rd_cnt - rd0 == 1, "R9 single read", rd_cnt - rd0, 1);
            check(rd_addr == v.ea, "R2 effective address", rd_addr, v.ea);
            if (v.op[7:6] == 2'b01) begin
                check(wr_cnt == wr0, "R10 no memory write", wr_cnt - wr0, 0);
            end else begin
                check(wr_cnt - wr0 == 1 && wr_addr == v.ea, "R3 write address", wr_addr, v.ea);
                check(wr_cyc == rd_cyc + 2, "R3 write two cycles after read", wr_cyc - rd_cyc, 2);
            end
            check(mem[v.ea[7:0]] == ((v.op[7:6] == 2'b01 || v.rom) ? v.init : v.res),
                  "R4 R5 memory result", mem[v.ea[7:0]], v.res);
            check(rg_cnt - rg0 == int'(v.regwe), "R7 R8 R10 register write count", rg_cnt - rg0, v.regwe);
            if (v.regwe) begin
                check(rg_sel == v.op[2:0], "R7 register select", rg_sel, v.op[2:0]);
                check(rg_data == v.res, "R9 register value", rg_data, v.res);
            end
            check(fl_cnt - fl0 == int'(v.flgwe), "R6 flag update", fl_cnt - fl0, v.flgwe);
            if (v.flgwe) begin
                check(fl_z == v.z, "R6 R10 zero flag", fl_z, v.z);
                check(fl_c == v.c, "R6 R10 carry flag", fl_c, v.c);
            end
            check(!busy, "R11 idle after done", busy, 0);
        end

        // R1: stray escape byte while idle is ignored
        rd0 = rd_cnt;
        send(8'hCB);
        check(!busy, "R1 non-prefix ignored", busy, 0);
        // R1: prefix then wrong escape abandons the sequence
        send(8'hDD);
        send(8'h00);
        check(!busy, "R1 abort on bad escape", busy, 0);
        send(8'h05);
        send(8'h06);
        repeat (6) @(negedge clk);
        check(rd_cnt == rd0, "R1 no access after abort", rd_cnt - rd0, 0);

        // R1: gaps between bytes are tolerated
        preload(8'h20, 8'h0F);
        ix_val = 16'h0020; carry_in = 1'b0;
        rg0 = rg_cnt;
        send(8'hDD); repeat (3) @(negedge clk);
        send(8'hCB); repeat (2) @(negedge clk);
        send(8'h00);
        send(8'hF8);              // set bit 7, copy to B
        wait_done(ok);
        check(ok && mem[8'h20] == 8'h8F, "R1 gapped sequence", mem[8'h20], 8'h8F);
        check(rg_cnt - rg0 == 1 && rg_data == 8'h8F && rg_sel == 3'd0, "R7 gapped copy", rg_data, 8'h8F);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule